// File: doc/BRIEF.md
# Segmented Bus Repeater Switch

This block sits at a segment boundary of a routing fabric. It joins the two sides of one local/express bus pair. Bus segments span eight cells, and a row and a column of these switches sit after every eighth cell, so the array falls into 8x8 sectors. Each side of the switch has two segment ports: one on the local bus and one on the express bus. That gives four ports in all. Each port is modelled as incoming data with an incoming drive enable. Each port also has registered outgoing data with an outgoing drive enable. A deasserted outgoing enable means the switch leaves that segment floating.

A 5-bit function code selects one connection function. One function isolates all the segments. Twenty functions send a single source port to a set of sink ports in one direction only. The set of functions is the same whichever side or bus type is the source. On switches that serve the second bus pair, an extra code joins the two local segments in both directions. Whichever local side drives takes the link, which is how long tri-state buses are built. If both local sides drive at once, a contention flag is raised and neither side is driven. Every output is registered, so a change at the inputs shows at the outputs one clock later.

Top module: `seg_repeater`

## Requirements
- R1: While `rst` is high at a rising edge, every outgoing drive enable, every outgoing data bus and `link_clash` are 0 after that edge.
- R2: Function code 0 leaves all four outgoing drive enables at 0.
- R3: Port numbers are 0 = side A local, 1 = side A express, 2 = side B local and 3 = side B express. Codes 1 to 20 select source `s = (code-1)/5` and pattern `k = (code-1)%5`. The sinks are {s^2} for k=0, {s^3} for k=1, {s^1} for k=2, {s^2, s^3} for k=3 and {s^2, s^1} for k=4. Each sink carries the source's incoming data.
- R4: Under codes 1 to 20, the source port and any other port outside the sink set keep their drive enable at 0.
- R5: A sink's drive enable is set only while the source's incoming drive enable is 1. When the source floats, every sink floats as well.
- R6: Codes 22 to 31 act as isolate. Code 21 also acts as isolate when the switch is built with `BIDIR_EN = 0`.
- R7: When `BIDIR_EN = 1` and the code is 21, a local port whose own incoming enable is 0 carries the other local port's data if that port's incoming enable is 1.
- R8: When the code is 21 and both local incoming enables are 1, `link_clash` is 1 and neither local port is driven.
- R9: Under code 21 both express ports stay undriven, and nothing is driven when neither local side drives.
- R10: Outputs reflect the inputs of the previous rising edge: a change in inputs does not alter outputs before the next rising edge. An undriven output carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_code | input | 5 | Connection function select |
| a_loc_d | input | WIDTH | Side A local segment data in |
| a_loc_en | input | 1 | Side A local segment is being driven |
| a_exp_d | input | WIDTH | Side A express segment data in |
| a_exp_en | input | 1 | Side A express segment is being driven |
| b_loc_d | input | WIDTH | Side B local segment data in |
| b_loc_en | input | 1 | Side B local segment is being driven |
| b_exp_d | input | WIDTH | Side B express segment data in |
| b_exp_en | input | 1 | Side B express segment is being driven |
| a_loc_q | output | WIDTH | Data driven onto side A local |
| a_loc_oe | output | 1 | Drive enable for side A local |
| a_exp_q | output | WIDTH | Data driven onto side A express |
| a_exp_oe | output | 1 | Drive enable for side A express |
| b_loc_q | output | WIDTH | Data driven onto side B local |
| b_loc_oe | output | 1 | Drive enable for side B local |
| b_exp_q | output | WIDTH | Data driven onto side B express |
| b_exp_oe | output | 1 | Drive enable for side B express |
| link_clash | output | 1 | Both local sides drove in bidirectional mode |

## Verification
Every one of the twenty directed codes is applied with a distinct data byte on each port, so a wrong source or sink shows up as a foreign byte or a stray enable. The same sweep is repeated with only the source enabled, and again with everything except the source enabled. These separate routing by code from gating by the source's enable. The bidirectional code is tried with A driving, B driving, both and neither, on a switch that has the mode and on one that does not. Unused codes, reset while inputs are active, and a data change held just short of a clock edge round out the set.

// File: rtl/seg_repeater_pkg.sv
package seg_repeater_pkg;
  localparam int NPORT     = 4;
  localparam int FUNC_W    = 5;
  localparam int NPAT      = 5;
  localparam int NSRC      = 4;
  localparam logic [FUNC_W-1:0] FN_ISOLATE  = 5'd0;
  localparam logic [FUNC_W-1:0] FN_DIR_LAST = 5'(NPAT * NSRC);
  localparam logic [FUNC_W-1:0] FN_BIDIR    = FN_DIR_LAST + 5'd1;

  typedef struct packed {
    logic [NPORT-1:0] sink;
    logic [1:0]       src;
    logic             bidir;
  } route_t;
endpackage

// File: rtl/seg_route_decode.sv
module seg_route_decode
  import seg_repeater_pkg::*;
#(
  parameter bit BIDIR_EN = 1'b1
) (
  input  logic [FUNC_W-1:0] func_code,
  output route_t            route
);
  logic [FUNC_W-1:0] idx;
  logic [1:0]        s;
  logic [2:0]        pat;

  always_comb begin
    route = '0;
    idx   = func_code - 5'd1;
    s     = 2'(idx / 5'(NPAT));
    pat   = 3'(idx % 5'(NPAT));
    if (func_code != FN_ISOLATE && func_code <= FN_DIR_LAST) begin
      route.src = s;
      case (pat)
        3'd0: route.sink[s ^ 2'd2] = 1'b1;
        3'd1: route.sink[s ^ 2'd3] = 1'b1;
        3'd2: route.sink[s ^ 2'd1] = 1'b1;
        3'd3: begin
          route.sink[s ^ 2'd2] = 1'b1;
          route.sink[s ^ 2'd3] = 1'b1;
        end
        default: begin
          route.sink[s ^ 2'd2] = 1'b1;
          route.sink[s ^ 2'd1] = 1'b1;
        end
      endcase
    end else if (func_code == FN_BIDIR && BIDIR_EN) begin
      route.bidir = 1'b1;
    end
  end

  always_comb begin
    if (route.bidir) assert (route.sink == '0) else $error("AST_BIDIR_NO_SINK"); // R7
  end
endmodule

// File: rtl/seg_port_drv.sv
module seg_port_drv
  import seg_repeater_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int PIDX  = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  route_t                      route,
  input  logic [NPORT-1:0][WIDTH-1:0] in_d,
  input  logic [NPORT-1:0]            in_en,
  output logic [WIDTH-1:0]            q,
  output logic                        oe
);
  localparam logic [1:0] ME       = 2'(PIDX);
  localparam logic [1:0] PEER     = ME ^ 2'd2;
  localparam bit         IS_LOCAL = (ME[0] == 1'b0);

  logic       sel;
  logic [1:0] src;
  logic       nxt_oe;

  always_comb begin
    if (route.bidir) begin
      src = PEER;
      sel = IS_LOCAL && in_en[PEER] && !in_en[ME];
    end else begin
      src = route.src;
      sel = route.sink[ME];
    end
    nxt_oe = sel & in_en[src];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      oe <= 1'b0;
    end else begin
      oe <= nxt_oe;
      q  <= nxt_oe ? in_d[src] : '0;
    end
  end

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst) !oe |-> (q == '0)); // R10
endmodule

// File: rtl/seg_repeater.sv
module seg_repeater
  import seg_repeater_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit BIDIR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FUNC_W-1:0] func_code,
  input  logic [WIDTH-1:0]  a_loc_d,
  input  logic              a_loc_en,
  input  logic [WIDTH-1:0]  a_exp_d,
  input  logic              a_exp_en,
  input  logic [WIDTH-1:0]  b_loc_d,
  input  logic              b_loc_en,
  input  logic [WIDTH-1:0]  b_exp_d,
  input  logic              b_exp_en,
  output logic [WIDTH-1:0]  a_loc_q,
  output logic              a_loc_oe,
  output logic [WIDTH-1:0]  a_exp_q,
  output logic              a_exp_oe,
  output logic [WIDTH-1:0]  b_loc_q,
  output logic              b_loc_oe,
  output logic [WIDTH-1:0]  b_exp_q,
  output logic              b_exp_oe,
  output logic              link_clash
);
  logic [NPORT-1:0][WIDTH-1:0] in_d;
  logic [NPORT-1:0]            in_en;
  logic [NPORT-1:0][WIDTH-1:0] out_q;
  logic [NPORT-1:0]            out_oe;
  route_t                      route;
  logic                        clash_q;

  assign in_d  = {b_exp_d, b_loc_d, a_exp_d, a_loc_d};
  assign in_en = {b_exp_en, b_loc_en, a_exp_en, a_loc_en};

  seg_route_decode #(.BIDIR_EN(BIDIR_EN)) u_decode (
    .func_code (func_code),
    .route     (route)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    seg_port_drv #(.WIDTH(WIDTH), .PIDX(p)) u_drv (
      .clk   (clk),
      .rst   (rst),
      .route (route),
      .in_d  (in_d),
      .in_en (in_en),
      .q     (out_q[p]),
      .oe    (out_oe[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) clash_q <= 1'b0;
    else     clash_q <= route.bidir & in_en[0] & in_en[2];
  end

  assign a_loc_q    = out_q[0];
  assign a_loc_oe   = out_oe[0];
  assign a_exp_q    = out_q[1];
  assign a_exp_oe   = out_oe[1];
  assign b_loc_q    = out_q[2];
  assign b_loc_oe   = out_oe[2];
  assign b_exp_q    = out_q[3];
  assign b_exp_oe   = out_oe[3];
  assign link_clash = clash_q;

  AST_ISOLATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (func_code == FN_ISOLATE) |=> (out_oe == '0)); // R2
  AST_SRC_NOT_SINK: assert property (@(posedge clk) disable iff (rst)
    (func_code != FN_ISOLATE && func_code <= FN_DIR_LAST)
    |=> !out_oe[2'(($past(func_code) - 5'd1) / 5'd5)]); // R4
  AST_FLOAT_SRC: assert property (@(posedge clk) disable iff (rst)
    (func_code != FN_ISOLATE && func_code <= FN_DIR_LAST
     && !in_en[2'((func_code - 5'd1) / 5'd5)]) |=> (out_oe == '0)); // R5
  AST_CLASH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    clash_q |-> (!out_oe[0] && !out_oe[2])); // R8
  AST_BIDIR_EXP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (func_code == FN_BIDIR) |=> (!out_oe[1] && !out_oe[3])); // R9
  AST_LOCAL_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    (func_code == FN_BIDIR) |=> $onehot0({out_oe[0], out_oe[2]})); // R7
endmodule

// File: tb/test_seg_repeater.sv
module test_seg_repeater;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] code = '0;
  logic [3:0][W-1:0] d = '0;
  logic [3:0] en = '0;
  logic [3:0][W-1:0] q1, q0;
  logic [3:0] oe1, oe0;
  logic clash1, clash0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_repeater #(.WIDTH(W), .BIDIR_EN(1'b1)) i_seg_repeater (
    .clk(clk), .rst(rst), .func_code(code),
    .a_loc_d(d[0]), .a_loc_en(en[0]), .a_exp_d(d[1]), .a_exp_en(en[1]),
    .b_loc_d(d[2]), .b_loc_en(en[2]), .b_exp_d(d[3]), .b_exp_en(en[3]),
    .a_loc_q(q1[0]), .a_loc_oe(oe1[0]), .a_exp_q(q1[1]), .a_exp_oe(oe1[1]),
    .b_loc_q(q1[2]), .b_loc_oe(oe1[2]), .b_exp_q(q1[3]), .b_exp_oe(oe1[3]),
    .link_clash(clash1));

  seg_repeater #(.WIDTH(W), .BIDIR_EN(1'b0)) i_seg_repeater_nobidir (
    .clk(clk), .rst(rst), .func_code(code),
    .a_loc_d(d[0]), .a_loc_en(en[0]), .a_exp_d(d[1]), .a_exp_en(en[1]),
    .b_loc_d(d[2]), .b_loc_en(en[2]), .b_exp_d(d[3]), .b_exp_en(en[3]),
    .a_loc_q(q0[0]), .a_loc_oe(oe0[0]), .a_exp_q(q0[1]), .a_exp_oe(oe0[1]),
    .b_loc_q(q0[2]), .b_loc_oe(oe0[2]), .b_exp_q(q0[3]), .b_exp_oe(oe0[3]),
    .link_clash(clash0));

  // Expected outputs, built from the requirement text
  task automatic model(input logic [4:0] c, input bit has_bidir,
                       input logic [3:0] e, input logic [3:0][W-1:0] dd,
                       output logic [3:0] xoe, output logic [3:0][W-1:0] xq,
                       output logic xclash);
    xoe = '0; xq = '0; xclash = 1'b0;
    if (c >= 5'd1 && c <= 5'd20) begin
      int s, k;
      logic [3:0] sinks;
      s = (int'(c) - 1) / 5;
      k = (int'(c) - 1) % 5;
      sinks = '0;
      case (k)
        0: sinks[s ^ 2] = 1'b1;
        1: sinks[s ^ 3] = 1'b1;
        2: sinks[s ^ 1] = 1'b1;
        3: begin sinks[s ^ 2] = 1'b1; sinks[s ^ 3] = 1'b1; end
        default: begin sinks[s ^ 2] = 1'b1; sinks[s ^ 1] = 1'b1; end
      endcase
      if (e[s]) begin
        xoe = sinks;
        for (int p = 0; p < 4; p++) if (sinks[p]) xq[p] = dd[s];
      end
    end else if (c == 5'd21 && has_bidir) begin
      xclash = e[0] & e[2];
      if (e[0] && !e[2]) begin xoe[2] = 1'b1; xq[2] = dd[0]; end
      if (e[2] && !e[0]) begin xoe[0] = 1'b1; xq[0] = dd[2]; end
    end
  endtask

  task automatic compare(input string tag, input logic [3:0] xoe1, input logic [3:0][W-1:0] xq1,
                         input logic xc1, input logic [3:0] xoe0, input logic [3:0][W-1:0] xq0);
    n_vec++;
    if (oe1 !== xoe1 || q1 !== xq1 || clash1 !== xc1) begin
      n_bad++;
      $display("FAIL %s code=%0d bidir: oe=%b q=%h clash=%b expected oe=%b q=%h clash=%b",
               tag, code, oe1, q1, clash1, xoe1, xq1, xc1);
    end
    n_vec++;
    if (oe0 !== xoe0 || q0 !== xq0 || clash0 !== 1'b0) begin
      n_bad++;
      $display("FAIL %s code=%0d plain: oe=%b q=%h clash=%b expected oe=%b q=%h clash=0",
               tag, code, oe0, q0, clash0, xoe0, xq0);
    end
  endtask

  task automatic apply(input string tag, input logic [4:0] c, input logic [3:0] e,
                       input logic [3:0][W-1:0] dd);
    logic [3:0] xo1, xo0;
    logic [3:0][W-1:0] xd1, xd0;
    logic xc1, xc0;
    @(negedge clk);
    code = c; en = e; d = dd;
    model(c, 1'b1, e, dd, xo1, xd1, xc1);
    model(c, 1'b0, e, dd, xo0, xd0, xc0);
    @(posedge clk); #1;
    compare(tag, xo1, xd1, xc1, xo0, xd0);
  endtask

  function automatic logic [3:0][W-1:0] pat_data(input int seed);
    logic [3:0][W-1:0] r;
    for (int p = 0; p < 4; p++) r[p] = W'((seed * 37 + p * 64 + 17) & 8'hFF);
    return r;
  endfunction

  task automatic test_reset();  // R1
    @(negedge clk);
    rst = 1'b1; code = 5'd21; en = 4'b0001; d = pat_data(3);
    @(posedge clk); #1;
    compare("R1", 4'b0, '0, 1'b0, 4'b0, '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic test_isolate();  // R2
    apply("R2", 5'd0, 4'b1111, pat_data(1));
    apply("R2", 5'd0, 4'b0101, pat_data(2));
  endtask

  task automatic test_directed();  // R3 R4
    for (int c = 1; c <= 20; c++) apply("R3_R4", 5'(c), 4'b1111, pat_data(c));
    for (int c = 1; c <= 20; c++) begin
      logic [3:0] only;
      only = '0; only[(c - 1) / 5] = 1'b1;
      apply("R3_R4", 5'(c), only, pat_data(c + 40));
    end
  endtask

  task automatic test_floating_source();  // R5
    for (int c = 1; c <= 20; c++) begin
      logic [3:0] rest;
      rest = 4'b1111; rest[(c - 1) / 5] = 1'b0;
      apply("R5", 5'(c), rest, pat_data(c + 80));
    end
  endtask

  task automatic test_unused_codes();  // R6
    for (int c = 22; c <= 31; c++) apply("R6", 5'(c), 4'b1111, pat_data(c));
    apply("R6", 5'd21, 4'b0001, pat_data(7));
  endtask

  task automatic test_bidir();  // R7 R9
    apply("R7", 5'd21, 4'b0001, pat_data(11));
    apply("R7", 5'd21, 4'b0100, pat_data(12));
    apply("R7", 5'd21, 4'b1011, pat_data(13));
    apply("R9", 5'd21, 4'b1010, pat_data(14));
    apply("R9", 5'd21, 4'b0000, pat_data(15));
  endtask

  task automatic test_clash();  // R8
    apply("R8", 5'd21, 4'b0101, pat_data(21));
    apply("R8", 5'd21, 4'b1111, pat_data(22));
    apply("R8", 5'd21, 4'b0001, pat_data(23));
  endtask

  task automatic test_latency();  // R10
    logic [3:0][W-1:0] first, second;
    first = pat_data(30); second = pat_data(31);
    apply("R10", 5'd1, 4'b0001, first);
    @(negedge clk); d = second; en = 4'b0000; code = 5'd0;
    #1;
    n_vec++;
    if (oe1 !== 4'b0100 || q1[2] !== first[0]) begin
      n_bad++;
      $display("FAIL R10 early: oe=%b q=%h expected oe=0100 q=%h", oe1, q1[2], first[0]);
    end
    apply("R10", 5'd1, 4'b0001, second);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    test_reset();
    test_isolate();
    test_directed();
    test_floating_source();
    test_unused_codes();
    test_bidir();
    test_clash();
    test_latency();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule